// File: doc/BRIEF.md
# DMA Ring-Buffer Address Generator

This block produces the source and destination addresses for one DMA channel. It also counts down the channel's transfer budget. Each side has its own step direction: up, down or hold. All sides share one step width, a byte or a 16-bit word. Each side can also be confined to an aligned power-of-two window, which turns its buffer into a ring. When the ring is off, the address walks linearly through memory, and the channel must be stopped by the terminal count.

A load strobe captures the starting addresses and the transfer budget. Each advance strobe stands for one completed transfer. It moves both addresses and decrements the budget. The transfer that uses up the budget raises a sticky terminal flag and idles the channel, and the channel stays idle until the next load.

For software that shares a ring with the DMA reader, the block also reports the number of bytes between the DMA's next source address and a software write pointer. This distance is measured around the source window. All outputs are registered.

Top module: `dma_ring_agen`

## Requirements
- R1: A load strobe captures `src_init`, `dst_init` and `tc_init` on the next clock edge and clears `tc_hit`. `active` becomes 1 exactly when `tc_init` is nonzero.
- R2: With its ring flag off, an address moves by one step per accepted advance over the full address width, carrying into the upper bits and wrapping modulo 2^AW.
- R3: With its ring flag on, an accepted advance changes only the address bits below the window size. Stepping up from the last unit of the window returns the address to the window base.
- R4: With its ring flag on, stepping down from the window base gives base + window size − step, which is the last byte or the last word of the window.
- R5: The source and destination ring flags act independently. One side can wrap while the other runs linearly in the same transfer.
- R6: The direction code is 2'b01 for up and 2'b10 for down. Codes 2'b00 and 2'b11 hold the address unchanged, whatever the ring flag.
- R7: The step is 2 bytes when `word_xfer` is 1 and 1 byte when it is 0.
- R8: Each accepted advance decrements `tc_count`. The advance that takes the count from 1 to 0 sets `tc_hit`, which stays set until the next load, and clears `active`. While `active` is 0, advances change neither the addresses nor the count. This includes a load with `tc_init` = 0.
- R9: Size code c in 0..6 selects a window of 2^(10+c) bytes, from 1 KB to 64 KB. Code 7 is treated as code 6.
- R10: `fill_bytes` equals (`sw_wr_ptr` − `src_addr`) modulo the source window size. It follows its inputs by one clock.
- R11: `cfg_err` is 1 one clock after a side has its ring flag on, `word_xfer` = 1 and an odd current address. Otherwise it is 0.
- R12: When load and advance are both high in the same cycle, the load wins, and the addresses equal the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture initial addresses and budget |
| advance | input | 1 | One transfer completed |
| src_init | input | AW | Initial source address |
| dst_init | input | AW | Initial destination address |
| tc_init | input | TCW | Initial transfer budget |
| src_dir | input | 2 | Source direction code |
| dst_dir | input | 2 | Destination direction code |
| word_xfer | input | 1 | 1: 2-byte step, 0: 1-byte step |
| src_ring | input | 1 | Source ring enable |
| dst_ring | input | 1 | Destination ring enable |
| src_size | input | 3 | Source window size code |
| dst_size | input | 3 | Destination window size code |
| sw_wr_ptr | input | AW | Software write pointer in the source ring |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| tc_count | output | TCW | Remaining transfers |
| tc_hit | output | 1 | Terminal count reached (sticky) |
| active | output | 1 | Channel accepts advances |
| fill_bytes | output | AW | Valid bytes ahead of the source pointer |
| cfg_err | output | 1 | Odd address with ring and word steps |

## Verification
The bench targets the window edges. It steps up from the last byte of a 1 KB window, steps down from the base of a 4 KB window in word mode, and uses size code 7. A generator that masked the wrong number of bits would leak a carry into the base, land on the wrong last word, or treat code 7 as a 128 KB window. A mixed case runs one ring side and one linear side through the same boundary, which exposes any shared ring flag. The bench also checks the budget ending on the 1→0 transfer and advances ignored afterwards, a load that wins over a simultaneous advance, and the ring distance when the write pointer has wrapped behind the read pointer. These catch an off-by-one stop, a leaking advance, and an unmasked subtraction that would report a huge count.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD     = 2'd0,
    STEP_UP       = 2'd1,
    STEP_DOWN     = 2'd2,
    STEP_HOLD_ALT = 2'd3
  } step_dir_e;

  localparam int unsigned WIN_MIN_LOG2 = 10;
  localparam int unsigned WIN_CODE_MAX = 6;

  // log2 of the window size in bytes; codes above the maximum saturate
  function automatic logic [4:0] win_log2(input logic [2:0] code);
    logic [2:0] c;
    c = (code > 3'(WIN_CODE_MAX)) ? 3'(WIN_CODE_MAX) : code;
    return 5'(WIN_MIN_LOG2) + {2'b00, c};
  endfunction

endpackage

// File: rtl/ring_win_mask.sv
module ring_win_mask
  import dma_ring_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic [2:0]    size_code,
  output logic [AW-1:0] mask
);
  logic [4:0] lg;
  assign lg = win_log2(size_code);

  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign mask[b] = (b < int'(lg));
  end
endmodule

// File: rtl/ring_addr_step.sv
module ring_addr_step
  import dma_ring_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] init,
  input  logic [1:0]    dir,
  input  logic          word,
  input  logic          ring_en,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] addr_q,
  output logic          odd_ring
);
  step_dir_e       d;
  logic [AW-1:0]   step;
  logic [AW-1:0]   lin_next;
  logic [AW-1:0]   nxt;

  assign d    = step_dir_e'(dir);
  assign step = word ? AW'(2) : AW'(1);

  always_comb begin
    unique case (d)
      STEP_UP:   lin_next = addr_q + step;
      STEP_DOWN: lin_next = addr_q - step;
      default:   lin_next = addr_q;
    endcase
    nxt = ring_en ? ((addr_q & ~mask) | (lin_next & mask)) : lin_next;
  end

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= init;
    else if (adv)  addr_q <= nxt;
  end

  assign odd_ring = ring_en & word & addr_q[0];

  // R3: a ring step never touches bits above the window
  p_stay_in_window_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && ring_en) |=> ((addr_q & ~$past(mask)) == ($past(addr_q) & ~$past(mask))));

  // R6: hold codes leave the address alone
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && (dir == 2'b00 || dir == 2'b11)) |=> $stable(addr_q));
endmodule

// File: rtl/ring_tc_counter.sv
module ring_tc_counter #(
  parameter int unsigned TCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           adv,
  input  logic [TCW-1:0] tc_init,
  output logic [TCW-1:0] cnt_q,
  output logic           hit_q,
  output logic           act_q
);
  logic last;
  assign last = (cnt_q == TCW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
      act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= tc_init;
      hit_q <= 1'b0;
      act_q <= (tc_init != '0);
    end else if (adv && act_q) begin
      cnt_q <= cnt_q - TCW'(1);
      if (last) begin
        hit_q <= 1'b1;
        act_q <= 1'b0;
      end
    end
  end

  // R8: the flag only rises on the transfer leaving a count of one
  p_tc_from_one_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_q) |-> ($past(cnt_q) == TCW'(1)));

  // R8: an idle channel keeps its count
  p_idle_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/ring_fill_meter.sv
module ring_fill_meter #(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_ptr,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] fill_q
);
  logic [AW-1:0] diff;
  assign diff = wr_ptr - rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) fill_q <= '0;
    else     fill_q <= diff & mask;
  end
endmodule

// File: rtl/dma_ring_agen.sv
module dma_ring_agen
  import dma_ring_pkg::*;
#(
  parameter int unsigned AW  = 24,
  parameter int unsigned TCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           advance,
  input  logic [AW-1:0]  src_init,
  input  logic [AW-1:0]  dst_init,
  input  logic [TCW-1:0] tc_init,
  input  logic [1:0]     src_dir,
  input  logic [1:0]     dst_dir,
  input  logic           word_xfer,
  input  logic           src_ring,
  input  logic           dst_ring,
  input  logic [2:0]     src_size,
  input  logic [2:0]     dst_size,
  input  logic [AW-1:0]  sw_wr_ptr,
  output logic [AW-1:0]  src_addr,
  output logic [AW-1:0]  dst_addr,
  output logic [TCW-1:0] tc_count,
  output logic           tc_hit,
  output logic           active,
  output logic [AW-1:0]  fill_bytes,
  output logic           cfg_err
);
  logic          step_en;
  logic [AW-1:0] src_mask, dst_mask;
  logic          src_odd, dst_odd;

  assign step_en = advance & active & ~load;

  ring_win_mask #(.AW(AW)) u_src_mask (.size_code(src_size), .mask(src_mask));
  ring_win_mask #(.AW(AW)) u_dst_mask (.size_code(dst_size), .mask(dst_mask));

  ring_addr_step #(.AW(AW)) u_src (
    .clk(clk), .rst(rst), .load(load), .adv(step_en), .init(src_init),
    .dir(src_dir), .word(word_xfer), .ring_en(src_ring), .mask(src_mask),
    .addr_q(src_addr), .odd_ring(src_odd)
  );

  ring_addr_step #(.AW(AW)) u_dst (
    .clk(clk), .rst(rst), .load(load), .adv(step_en), .init(dst_init),
    .dir(dst_dir), .word(word_xfer), .ring_en(dst_ring), .mask(dst_mask),
    .addr_q(dst_addr), .odd_ring(dst_odd)
  );

  ring_tc_counter #(.TCW(TCW)) u_tc (
    .clk(clk), .rst(rst), .load(load), .adv(step_en), .tc_init(tc_init),
    .cnt_q(tc_count), .hit_q(tc_hit), .act_q(active)
  );

  ring_fill_meter #(.AW(AW)) u_fill (
    .clk(clk), .rst(rst), .wr_ptr(sw_wr_ptr), .rd_ptr(src_addr),
    .mask(src_mask), .fill_q(fill_bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= src_odd | dst_odd;
  end

  // R8: a finished channel is idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    tc_hit |-> !active);

  // R12: load beats a simultaneous advance
  p_load_wins_r12: assert property (@(posedge clk) disable iff (rst)
    load |=> (src_addr == $past(src_init) && dst_addr == $past(dst_init)));
endmodule

// File: tb/test_dma_ring_agen.sv
`timescale 1ns/1ps
module test_dma_ring_agen;
  localparam int AW  = 24;
  localparam int TCW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 0, advance = 0, word_xfer = 0, src_ring = 0, dst_ring = 0;
  logic [AW-1:0] src_init = '0, dst_init = '0, sw_wr_ptr = '0;
  logic [TCW-1:0] tc_init = '0;
  logic [1:0] src_dir = 0, dst_dir = 0;
  logic [2:0] src_size = 0, dst_size = 0;
  logic [AW-1:0] src_addr, dst_addr, fill_bytes;
  logic [TCW-1:0] tc_count;
  logic tc_hit, active, cfg_err;

  dma_ring_agen #(.AW(AW), .TCW(TCW)) i_dma_ring_agen (.*);

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [AW-1:0] m_src = '0, m_dst = '0, m_fill = '0;
  logic [TCW-1:0] m_cnt = '0;
  logic m_hit = 0, m_act = 0, m_err = 0;

  function automatic logic [AW-1:0] win_mask(input logic [2:0] c);
    int lg;
    lg = 10 + ((c > 3'd6) ? 6 : int'(c));
    return AW'((32'd1 << lg) - 32'd1);
  endfunction

  function automatic logic [AW-1:0] m_next(input logic [AW-1:0] a, input logic [1:0] d,
                                           input logic w, input logic rg, input logic [2:0] c);
    logic [AW-1:0] s, st, mk;
    st = w ? AW'(2) : AW'(1);
    s  = (d == 2'b01) ? a + st : (d == 2'b10) ? a - st : a;
    mk = win_mask(c);
    return rg ? ((a & ~mk) | (s & mk)) : s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare one ns later
  task automatic cycle();
    logic [AW-1:0] nf;
    logic ne;
    @(posedge clk);
    nf = (sw_wr_ptr - m_src) & win_mask(src_size);
    ne = (src_ring & word_xfer & m_src[0]) | (dst_ring & word_xfer & m_dst[0]);
    if (load) begin
      m_src = src_init; m_dst = dst_init; m_cnt = tc_init;
      m_hit = 0; m_act = (tc_init != 0);
    end else if (advance && m_act) begin
      m_src = m_next(m_src, src_dir, word_xfer, src_ring, src_size);
      m_dst = m_next(m_dst, dst_dir, word_xfer, dst_ring, dst_size);
      if (m_cnt == 1) begin m_hit = 1; m_act = 0; end
      m_cnt = m_cnt - 1'b1;
    end
    m_fill = nf; m_err = ne;
    #1;
    chk("R2 src_addr", 32'(src_addr), 32'(m_src));
    chk("R5 dst_addr", 32'(dst_addr), 32'(m_dst));
    chk("R8 tc_count", 32'(tc_count), 32'(m_cnt));
    chk("R8 tc_hit", 32'(tc_hit), 32'(m_hit));
    chk("R1 active", 32'(active), 32'(m_act));
    chk("R10 fill_bytes", 32'(fill_bytes), 32'(m_fill));
    chk("R11 cfg_err", 32'(cfg_err), 32'(m_err));
  endtask

  task automatic do_load(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [TCW-1:0] t);
    src_init = s; dst_init = d; tc_init = t; load = 1; advance = 0;
    cycle();
    load = 0;
  endtask

  task automatic do_adv();
    advance = 1; cycle(); advance = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    // reset state, R1
    chk("R1 reset src", 32'(src_addr), 0);
    chk("R1 reset tc_count", 32'(tc_count), 0);
    chk("R1 reset active", 32'(active), 0);
    cycle();

    // R3/R9: byte up from last byte of 1 KB window
    src_dir = 2'b01; src_ring = 1; src_size = 0; word_xfer = 0;
    do_load(24'h1203FF, 24'h0, 16'd10);
    chk("R1 load src", 32'(src_addr), 32'h1203FF);
    do_adv();
    chk("R3 wrap to base", 32'(src_addr), 32'h120000);

    // R4/R7: word down from base of 4 KB window
    src_dir = 2'b10; src_size = 2; word_xfer = 1;
    do_load(24'h345000, 24'h0, 16'd10);
    do_adv();
    chk("R4 down wrap last word", 32'(src_addr), 32'h345FFE);
    chk("R7 word step count", 32'(tc_count), 9);

    // R2: linear carry; R5: mixed rings
    word_xfer = 0; src_dir = 2'b01; dst_dir = 2'b01; src_size = 0; dst_size = 0;
    src_ring = 1; dst_ring = 0;
    do_load(24'h0007FF, 24'h0003FF, 16'd5);
    do_adv();
    chk("R5 src ring", 32'(src_addr), 32'h000400);
    chk("R2 dst linear carry", 32'(dst_addr), 32'h000400);

    // R6: hold codes with ring on
    src_dir = 2'b00; dst_dir = 2'b11; dst_ring = 1;
    do_load(24'h0003FF, 24'h0007FF, 16'd5);
    do_adv();
    chk("R6 hold 00", 32'(src_addr), 32'h0003FF);
    chk("R6 hold 11", 32'(dst_addr), 32'h0007FF);

    // R9: code 7 behaves as 64 KB
    src_dir = 2'b01; src_size = 3'd7; src_ring = 1;
    do_load(24'h0AFFFF, 24'h0, 16'd5);
    do_adv();
    chk("R9 code7 window", 32'(src_addr), 32'h0A0000);

    // R8: budget of 2 then an ignored advance
    src_size = 0; src_ring = 0;
    do_load(24'h000100, 24'h0, 16'd2);
    do_adv();
    chk("R8 not yet hit", 32'(tc_hit), 0);
    do_adv();
    chk("R8 hit on 1->0", 32'(tc_hit), 1);
    chk("R8 idle", 32'(active), 0);
    do_adv();
    chk("R8 ignored advance", 32'(src_addr), 32'h000102);
    chk("R8 sticky", 32'(tc_hit), 1);
    do_load(24'h000200, 24'h0, 16'd0);
    do_adv();
    chk("R8 zero budget ignored", 32'(src_addr), 32'h000200);

    // R12: load with advance
    do_load(24'h000300, 24'h0, 16'd4);
    src_init = 24'h000500; load = 1; advance = 1;
    cycle();
    load = 0; advance = 0;
    chk("R12 load wins", 32'(src_addr), 32'h000500);

    // R10: distance and wrapped distance, 4 KB source window
    src_size = 2;
    do_load(24'h200050, 24'h0, 16'd4);
    sw_wr_ptr = 24'h200150;
    cycle();
    chk("R10 fill 0x100", 32'(fill_bytes), 32'h100);
    do_load(24'h200F00, 24'h0, 16'd4);
    sw_wr_ptr = 24'h200010;
    cycle();
    chk("R10 wrapped fill", 32'(fill_bytes), 32'h110);

    // R11: odd address, ring, word
    src_ring = 1; word_xfer = 1; dst_ring = 0;
    do_load(24'h000101, 24'h0, 16'd4);
    cycle();
    chk("R11 odd ring word", 32'(cfg_err), 1);
    word_xfer = 0;
    cycle();
    chk("R11 byte mode clean", 32'(cfg_err), 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      src_dir   = 2'($urandom);
      dst_dir   = 2'($urandom);
      word_xfer = 1'($urandom);
      src_ring  = 1'($urandom);
      dst_ring  = 1'($urandom);
      src_size  = 3'($urandom);
      dst_size  = 3'($urandom);
      sw_wr_ptr = AW'($urandom);
      load      = (($urandom % 20) == 0);
      advance   = 1'($urandom);
      src_init  = AW'($urandom);
      dst_init  = AW'($urandom);
      tc_init   = TCW'($urandom % 24);
      cycle();
    end
    load = 0; advance = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule